// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Control Register Bank

This block is a bank of nine 32-bit registers for a peripheral such as a USB PHY, reached over a simple word-aligned register bus inside a 4 KiB byte window. Six of the registers each take up four consecutive words. The first word is the register itself. The next three are alias addresses. Writing one of them ORs, clears (AND-NOT) or XORs the write data into the register, so software can change single bits without a read-modify-write. The other three registers (status, debug-zero status and version) each take up one word.

The bank has two reset levels. The asynchronous hardware reset loads every register. A soft reset is triggered from bit 31 of the control register and reloads only power-down, transmit, receive and control. The block returns read data and an error pulse one cycle after each request.

An access is refused when it is misaligned, beyond the last register, or a write to a read-only register. A refused access raises the error flag and changes no register.

Top module: `stc_regbank`

## Requirements
- R1: After hardware reset the registers read power-down 0x001E1C00, transmit 0x10060607, receive 0x00000000, control 0xC0200000, status 0x00000000, debug 0x7F180000, debug0-status 0x00000000, debug1 0x00001000 and version 0x04020000.
- R2: Word addresses (byte address / 4) are: power-down 0-3, transmit 4-7, receive 8-11, control 12-15, status 16, debug 17-20, debug0-status 21, debug1 22-25 and version 26. Within a four-word group, offset 0 is the register, 1 is set, 2 is clear and 3 is toggle. A base write stores the data, and a read of any word in a group returns the register.
- R3: A write to a set alias ORs the write data into its register.
- R4: A write to a clear alias clears the register bits where the write data is 1. This holds for control too, where it never starts a soft reset.
- R5: A write to a toggle alias XORs the write data into its register.
- R6: A write with bit 31 set to the control base word or control set alias starts a soft reset. Power-down, transmit, receive and control take their R1 values, and status, debug and debug1 are kept.
- R7: A write to the control toggle alias starts a soft reset only when bit 31 of the data is 1 and bit 31 of control after the XOR is 1. Otherwise control keeps the XOR result.
- R8: Status accepts direct writes. Writes to debug0-status and version change nothing and raise the error flag.
- R9: A read from a word at index 27 or above returns zero and raises the error flag. A write there changes nothing and raises the error flag.
- R10: An access whose byte address has bits [1:0] non-zero raises the error flag, returns zero read data and changes no register.
- R11: Read data and the error flag are registered. They belong to the request of the previous clock cycle, and the error flag is 0 after a legal access or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | ADDR_W (12) | Byte address in the window |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W (32) | Read data, one cycle after rd_en |
| err | output | 1 | One-cycle pulse for a refused access |

## Verification
A write changes its register at the edge that samples the request. A read issued in the next cycle therefore shows the new value. Read data and the error flag are due exactly one edge after the request. Every bench access drives its inputs on a falling edge, waits for the next falling edge, and compares rd_data and err there against a bench model. The model is updated only after that comparison, so each expected value comes from the state as it was before the access.

// File: rtl/stc_pkg.sv
package stc_pkg;
   localparam int NREG     = 9;
   localparam int IDX_W    = 4;
   localparam int REG_W    = 32;
   localparam int LAST_W   = 27;   // first word index beyond the bank

   localparam int RG_PWD  = 0;
   localparam int RG_TX   = 1;
   localparam int RG_RX   = 2;
   localparam int RG_CTRL = 3;
   localparam int RG_STAT = 4;
   localparam int RG_DBG  = 5;
   localparam int RG_DBG0 = 6;
   localparam int RG_DBG1 = 7;
   localparam int RG_VER  = 8;

   typedef enum logic [1:0] {
      OP_WR  = 2'd0,
      OP_SET = 2'd1,
      OP_CLR = 2'd2,
      OP_TOG = 2'd3
   } alias_op_e;

   function automatic int base_word(input int i);
      case (i)
         RG_PWD:  return 0;
         RG_TX:   return 4;
         RG_RX:   return 8;
         RG_CTRL: return 12;
         RG_STAT: return 16;
         RG_DBG:  return 17;
         RG_DBG0: return 21;
         RG_DBG1: return 22;
         default: return 26;
      endcase
   endfunction

   function automatic bit has_alias(input int i);
      return !(i == RG_STAT || i == RG_DBG0 || i == RG_VER);
   endfunction

   function automatic bit is_writable(input int i);
      return !(i == RG_DBG0 || i == RG_VER);
   endfunction

   function automatic bit in_soft_set(input int i);
      return i <= RG_CTRL;
   endfunction

   function automatic logic [REG_W-1:0] hw_default(input int i);
      case (i)
         RG_PWD:  return 32'h001E_1C00;
         RG_TX:   return 32'h1006_0607;
         RG_CTRL: return 32'hC020_0000;
         RG_DBG:  return 32'h7F18_0000;
         RG_DBG1: return 32'h0000_1000;
         RG_VER:  return 32'h0402_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction
endpackage

// File: rtl/stc_decode.sv
module stc_decode
   import stc_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output alias_op_e         op
);
   int wi;

   always_comb begin
      wi  = int'(addr[ADDR_W-1:2]);
      hit = 1'b0;
      idx = '0;
      op  = OP_WR;
      if (addr[1:0] == 2'b00) begin
         for (int i = 0; i < NREG; i++) begin
            if (has_alias(i)) begin
               if (wi >= base_word(i) && wi < base_word(i) + 4) begin
                  hit = 1'b1;
                  idx = IDX_W'(i);
                  op  = alias_op_e'(2'(wi - base_word(i)));
               end
            end else if (wi == base_word(i)) begin
               hit = 1'b1;
               idx = IDX_W'(i);
               op  = OP_WR;
            end
         end
      end
   end
endmodule

// File: rtl/stc_alias_alu.sv
module stc_alias_alu
   import stc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] din,
   input  alias_op_e         op,
   output logic [DATA_W-1:0] nxt
);
   always_comb begin
      case (op)
         OP_SET:  nxt = cur | din;
         OP_CLR:  nxt = cur & ~din;
         OP_TOG:  nxt = cur ^ din;
         default: nxt = din;
      endcase
   end

   always_comb begin
      if (op == OP_SET)
         AST_SET_KEEPS_ONES: assert ((nxt & cur) == cur); // R3
      if (op == OP_CLR)
         AST_CLR_ADDS_NO_ONES: assert ((nxt & ~cur) == '0); // R4
   end
endmodule

// File: rtl/stc_regbank.sv
module stc_regbank
   import stc_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int SRST_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              err
);
   localparam int FLAT_W = NREG * DATA_W;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("stc_regbank: DATA_W must equal the 32-bit register width");
   end
   if ((1 << (ADDR_W - 2)) < LAST_W) begin : g_bad_addr
      $error("stc_regbank: ADDR_W too narrow for the register map");
   end
   if (SRST_BIT >= DATA_W) begin : g_bad_srst
      $error("stc_regbank: SRST_BIT outside the data word");
   end

   logic              hit;
   logic [IDX_W-1:0]  idx;
   alias_op_e         op;
   logic [DATA_W-1:0] cur, nxt;
   logic [FLAT_W-1:0] regs_flat;
   logic              wr_ok, srst;

   stc_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .hit  (hit),
      .idx  (idx),
      .op   (op)
   );

   assign cur = regs_flat[int'(idx)*DATA_W +: DATA_W];

   stc_alias_alu #(.DATA_W(DATA_W)) u_alu (
      .cur (cur),
      .din (wr_data),
      .op  (op),
      .nxt (nxt)
   );

   assign wr_ok = wr_en && hit && is_writable(int'(idx));

   always_comb begin
      srst = 1'b0;
      if (wr_ok && int'(idx) == RG_CTRL && wr_data[SRST_BIT]) begin
         if (op == OP_WR || op == OP_SET) srst = 1'b1;
         else if (op == OP_TOG)           srst = nxt[SRST_BIT];
      end
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      if (!is_writable(i)) begin : g_const
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= hw_default(i);
         end
      end else if (in_soft_set(i)) begin : g_soft
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      q <= hw_default(i);
            else if (srst)                   q <= hw_default(i);
            else if (wr_ok && int'(idx) == i) q <= nxt;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      q <= hw_default(i);
            else if (wr_ok && int'(idx) == i) q <= nxt;
         end
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         err     <= 1'b0;
      end else begin
         rd_data <= (rd_en && hit) ? cur : '0;
         err     <= (wr_en && !wr_ok) || (rd_en && !hit);
      end
   end

   logic [DATA_W-1:0] ctrl_q;
   assign ctrl_q = regs_flat[RG_CTRL*DATA_W +: DATA_W];

   AST_ERR_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(wr_en || rd_en)); // R11

   AST_REFUSED_WRITE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> $stable(regs_flat)); // R8

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> (rd_data == '0 && err)); // R9

   AST_SRST_LOADS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> ctrl_q == hw_default(RG_CTRL)); // R6

   AST_TOG_CTRL_NO_SRST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && int'(idx) == RG_CTRL && op == OP_TOG && !wr_data[SRST_BIT])
      |=> ctrl_q == $past(ctrl_q ^ wr_data)); // R7

   AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && hit && int'(idx) == RG_VER) |=> rd_data == hw_default(RG_VER)); // R8
endmodule

// File: tb/stc_regbank_test.sv
`timescale 1ns/1ps
module stc_regbank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [31:0] m [9];

   always #2.5 clk = ~clk;

   stc_regbank uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .err(err)
   );

   function automatic logic [31:0] dflt(input int j);
      case (j)
         0: return 32'h001E1C00;
         1: return 32'h10060607;
         3: return 32'hC0200000;
         5: return 32'h7F180000;
         7: return 32'h00001000;
         8: return 32'h04020000;
         default: return 32'h0;
      endcase
   endfunction

   // word index -> register (-1 none), alias offset
   function automatic int find_reg(input int w, output int off);
      int bases [9] = '{0, 4, 8, 12, 16, 17, 21, 22, 26};
      int span  [9] = '{4, 4, 4, 4, 1, 4, 1, 4, 1};
      off = 0;
      for (int j = 0; j < 9; j++)
         if (w >= bases[j] && w < bases[j] + span[j]) begin
            off = w - bases[j];
            return j;
         end
      return -1;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [11:0] a,
                         input logic [31:0] d, input string tag);
      int off, j, w;
      bit exp_err;
      logic [31:0] exp_rd, n;
      w = int'(a[11:2]);
      j = (a[1:0] != 0) ? -1 : find_reg(w, off);
      exp_rd  = (j < 0) ? 32'h0 : m[j];
      exp_err = (j < 0) || (we && (j == 6 || j == 8));
      @(negedge clk);
      addr = a; wr_data = d; wr_en = we; rd_en = !we;
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      check(tag, "err", {31'b0, err}, {31'b0, exp_err});
      if (!we) check(tag, "rd_data", rd_data, exp_rd);
      if (we && !exp_err) begin
         case (off)
            1: n = m[j] | d;
            2: n = m[j] & ~d;
            3: n = m[j] ^ d;
            default: n = d;
         endcase
         if (j == 3 && d[31] && ((off <= 1) || (off == 3 && n[31]))) begin
            for (int k = 0; k < 4; k++) m[k] = dflt(k);
         end else m[j] = n;
      end
   endtask

   task automatic rd_word(input int w, input string tag);
      access(0, 12'(w * 4), 32'h0, tag);
   endtask

   task automatic wr_word(input int w, input logic [31:0] d, input string tag);
      access(1, 12'(w * 4), d, tag);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < 9; k++) m[k] = dflt(k);
      #12 rst_n = 1'b1;

      // R1: reset values
      foreach (m[k]) begin
         int b [9] = '{0, 4, 8, 12, 16, 17, 21, 22, 26};
         rd_word(b[k], "R1");
      end
      // R11: idle cycle leaves err low
      @(negedge clk); @(negedge clk);
      check("R11", "idle err", {31'b0, err}, 32'h0);

      // R2: base write, alias reads
      wr_word(0, 32'hA5A5_0F0F, "R2");
      rd_word(1, "R2"); rd_word(2, "R2"); rd_word(3, "R2");
      // R3, R4, R5 on transmit and debug1
      wr_word(5, 32'h0000_F000, "R3"); rd_word(4, "R3");
      wr_word(6, 32'h1000_0007, "R4"); rd_word(4, "R4");
      wr_word(7, 32'hFFFF_0000, "R5"); rd_word(4, "R5");
      wr_word(23, 32'h0000_00FF, "R3"); rd_word(22, "R3");
      wr_word(25, 32'h0000_10F0, "R5"); rd_word(22, "R5");
      // R8: status writable, debug0/version refused
      wr_word(16, 32'hDEAD_BEEF, "R8"); rd_word(16, "R8");
      wr_word(21, 32'h1234_5678, "R8"); rd_word(21, "R8");
      wr_word(26, 32'hFFFF_FFFF, "R8"); rd_word(26, "R8");
      wr_word(17, 32'h0101_0101, "R2");
      // R6: base write with bit 31
      wr_word(8, 32'h0000_00AA, "R6");
      wr_word(12, 32'h8000_0001, "R6");
      rd_word(0, "R6"); rd_word(4, "R6"); rd_word(8, "R6"); rd_word(12, "R6");
      rd_word(16, "R6"); rd_word(17, "R6"); rd_word(22, "R6");
      // R6: set alias
      wr_word(0, 32'h0, "R6"); wr_word(13, 32'h8000_0000, "R6"); rd_word(0, "R6");
      // R4: clear alias with bit 31 does not reset
      wr_word(4, 32'h0, "R4"); wr_word(14, 32'h8000_0000, "R4");
      rd_word(12, "R4"); rd_word(4, "R4");
      // R7: toggle 0->1 resets, then 1->0 does not
      wr_word(15, 32'h8000_0003, "R7"); rd_word(12, "R7"); rd_word(4, "R7");
      wr_word(4, 32'h5, "R7");
      wr_word(15, 32'h8000_0010, "R7"); rd_word(12, "R7"); rd_word(4, "R7");
      wr_word(15, 32'h0000_0100, "R7"); rd_word(12, "R7");
      // R9: beyond the last register
      rd_word(27, "R9"); rd_word(31, "R9"); rd_word(1023, "R9");
      wr_word(27, 32'hFFFF_FFFF, "R9"); wr_word(700, 32'h1, "R9");
      // R10: misaligned
      access(0, 12'h002, 32'h0, "R10");
      access(1, 12'h031, 32'h8000_0000, "R10");
      access(1, 12'h043, 32'hFFFF_FFFF, "R10");
      rd_word(12, "R10"); rd_word(16, "R10");

      // random mix
      for (int it = 0; it < 600; it++) begin
         int w;
         logic [11:0] a;
         logic [31:0] d;
         w = ($urandom % 8 == 0) ? int'($urandom % 1024) : int'($urandom % 32);
         a = 12'(w * 4);
         if ($urandom % 16 == 0) a[1:0] = 2'($urandom % 3 + 1);
         d = $urandom;
         access(($urandom % 2) == 1, a, d, "R2");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule